// File: doc/BRIEF.md
# Interrupt Flag and Low-Power Wake Controller

This block gathers the interrupt events of a small microcontroller: a 64 Hz tick, a half-second watch tick, a timer expiry pulse and a set of level-sensitive port pins. It keeps three pending flags that software reads and clears by writing zeros. From these it drives a non-maskable request pulse and a single combined maskable request toward the CPU. All tick and expiry inputs are single-cycle enable pulses from dividers outside the block.

The block also owns the power state. A write to the standby selector or to the sleep selector moves it out of RUN. It then halts the CPU clock and, depending on the state, stops the main oscillator, the sub oscillator and the display. Each low-power state has its own set of sources that may wake it. A wake event is shown for one cycle and returns the block to RUN on the next clock edge.

Top module: `irq_wake_ctrl`

## Requirements
- R1: `rdFlags` bit 0 is the watch-tick flag, bit 1 the timer flag and bit 2 the port flag; all flags, enables, directions and the power state are 0 after reset.
- R2: A flag write (`wrSel`=0) clears each flag whose `wrData` bit is 0 and leaves flags whose bit is 1 unchanged. A flag's own event in the same cycle keeps it set.
- R3: The port flag is set in every cycle in which some pin is low and has its direction bit 0 (input, `wrSel`=3) and its interrupt-enable bit 1 (`wrSel`=4). A pin set as output or not enabled never sets it, so a held-low pin re-sets the flag after a clear.
- R4: `irqReq` = (flag0 AND control bit 6) OR (flag1 AND control bit 1) OR flag2, where the control register is `wrSel`=1. It stays high for as long as such a flag is uncleared.
- R5: `nmiPulse` is high for exactly the one cycle after a `tick64` pulse that arrives while control bit 2 is 1, and is never high otherwise.
- R6: Watch register (`wrSel`=2) bit 0 selects the rate: 0 sets flag0 on every `halfSecTick` (2 Hz), and 1 sets it only on every second `halfSecTick` counted from reset (1 Hz).
- R7: A write with `wrSel`=5 in RUN enters STANDBY: `cpuHalt`=1, no oscillator stopped, display on. It wakes on an enabled 64 Hz tick or on `irqReq`, and on nothing else.
- R8: A write with `wrSel`=6 and `wrData` bit 0 = 1 enters SLEEP1: halt, both oscillators stopped, `displayOff`=1. Only a pending port flag wakes it.
- R9: A write with `wrSel`=6, bit 1 = 1 and bit 0 = 0 enters SLEEP2: halt and main oscillator stopped only. An enabled 64 Hz tick, an enabled pending watch flag or a pending port flag wakes it, and the timer flag does not.
- R10: A sleep write with both bits set enters SLEEP1. A sleep write with neither bit set leaves the block in RUN.
- R11: `wakeEvt` is high in the cycle in which a wake condition holds in a low-power state, and never in RUN. At the next edge the state is RUN, all stop outputs are 0, and the flags are kept.
- R12: `pwrState` encodes RUN=0, STANDBY=1, SLEEP1=2, SLEEP2=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick64 | input | 1 | 64 Hz enable pulse |
| halfSecTick | input | 1 | 2 Hz watch enable pulse |
| timerDone | input | 1 | Timer expiry pulse |
| portIn | input | PINS | Port pin levels |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 3 | Register selector |
| wrData | input | DATA_W | Write data |
| rdFlags | output | 3 | Pending flags |
| irqReq | output | 1 | Combined maskable request |
| nmiPulse | output | 1 | Non-maskable request pulse |
| wakeEvt | output | 1 | Wake event strobe |
| pwrState | output | 2 | Current power state |
| cpuHalt | output | 1 | CPU clock halted |
| mainOscStop | output | 1 | Main oscillator stop |
| subOscStop | output | 1 | Sub oscillator stop |
| displayOff | output | 1 | Display forced off |

## Verification
The assertions take for granted that tick and expiry inputs are single-cycle pulses and that the port pins are already synchronous to `clk`. They also assume that register writes are issued only while the block is in RUN, as a halted CPU would issue them. The bench changes every input on the falling edge and leaves each pulse high for one cycle only. It clears the flags before every entry into a low-power state, so that no stale flag can cause an early wake. The sweeps run over flag patterns, clear masks, enable combinations and every pin with each direction and enable setting.

// File: rtl/irq_wake_pkg.sv
package irq_wake_pkg;

  typedef enum logic [2:0] {
    SEL_FLAGS   = 3'd0,
    SEL_CTRL    = 3'd1,
    SEL_WATCH   = 3'd2,
    SEL_DIR     = 3'd3,
    SEL_IEN     = 3'd4,
    SEL_STANDBY = 3'd5,
    SEL_SLEEP   = 3'd6
  } regSel_e;

  typedef enum logic [1:0] {
    PWR_RUN     = 2'd0,
    PWR_STANDBY = 2'd1,
    PWR_SLEEP1  = 2'd2,
    PWR_SLEEP2  = 2'd3
  } pwrState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic flagWr;
    logic ctrlWr;
    logic watchWr;
    logic dirWr;
    logic ienWr;
  } regStrobe_t;

  // wake sources from datapath to control
  typedef struct packed {
    logic nmiEvt;
    logic irqPend;
    logic watchPend;
    logic portPend;
  } wakeSrc_t;

  localparam int FLAG_W        = 3;
  localparam int FLAG_WATCH    = 0;
  localparam int FLAG_TIMER    = 1;
  localparam int FLAG_PORT     = 2;
  localparam int CTRL_TMR_EN   = 1;
  localparam int CTRL_NMI_EN   = 2;
  localparam int CTRL_WATCH_EN = 6;
  localparam int SLEEP1_BIT    = 0;
  localparam int SLEEP2_BIT    = 1;

endpackage

// File: rtl/irq_wake_dp.sv
module irq_wake_dp
  import irq_wake_pkg::*;
#(
  parameter int PINS   = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick64,
  input  logic              halfSecTick,
  input  logic              timerDone,
  input  logic [PINS-1:0]   portIn,
  input  regStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [FLAG_W-1:0] rdFlags,
  output logic              irqReq,
  output logic              nmiPulse,
  output wakeSrc_t          wakeSrc
);

  logic [FLAG_W-1:0] flagQ, flagD, setVec, keepVec;
  logic tmrEnQ, nmiEnQ, watchEnQ, rate1HzQ, phaseQ, nmiQ;
  logic [PINS-1:0] dirQ, ienQ, pinHit;
  logic watchHit, portHit;

  // per-pin interrupt qualification
  for (genvar i = 0; i < PINS; i++) begin : g_pin
    assign pinHit[i] = ~portIn[i] & ienQ[i] & ~dirQ[i];
  end

  assign portHit  = |pinHit;
  assign watchHit = halfSecTick & (~rate1HzQ | phaseQ);

  always_comb begin
    setVec             = '0;
    setVec[FLAG_WATCH] = watchHit;
    setVec[FLAG_TIMER] = timerDone;
    setVec[FLAG_PORT]  = portHit;
    keepVec = strobe.flagWr ? wrData[FLAG_W-1:0] : '1;
    flagD   = (flagQ & keepVec) | setVec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ    <= '0;
      tmrEnQ   <= 1'b0;
      nmiEnQ   <= 1'b0;
      watchEnQ <= 1'b0;
      rate1HzQ <= 1'b0;
      phaseQ   <= 1'b0;
      dirQ     <= '0;
      ienQ     <= '0;
      nmiQ     <= 1'b0;
    end else begin
      flagQ <= flagD;
      nmiQ  <= tick64 & nmiEnQ;
      if (halfSecTick) phaseQ <= ~phaseQ;
      if (strobe.ctrlWr) begin
        tmrEnQ   <= wrData[CTRL_TMR_EN];
        nmiEnQ   <= wrData[CTRL_NMI_EN];
        watchEnQ <= wrData[CTRL_WATCH_EN];
      end
      if (strobe.watchWr) rate1HzQ <= wrData[0];
      if (strobe.dirWr)   dirQ     <= wrData[PINS-1:0];
      if (strobe.ienWr)   ienQ     <= wrData[PINS-1:0];
    end
  end

  assign rdFlags  = flagQ;
  assign nmiPulse = nmiQ;
  assign irqReq   = (flagQ[FLAG_WATCH] & watchEnQ) |
                    (flagQ[FLAG_TIMER] & tmrEnQ) |
                    flagQ[FLAG_PORT];

  assign wakeSrc.nmiEvt    = tick64 & nmiEnQ;
  assign wakeSrc.irqPend   = irqReq;
  assign wakeSrc.watchPend = flagQ[FLAG_WATCH] & watchEnQ;
  assign wakeSrc.portPend  = flagQ[FLAG_PORT];

endmodule

// File: rtl/irq_wake_fsm.sv
module irq_wake_fsm
  import irq_wake_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [2:0] wrSel,
  input  logic [1:0] sleepBits,
  input  wakeSrc_t   wakeSrc,
  output regStrobe_t strobe,
  output logic [1:0] pwrState,
  output logic       wakeEvt,
  output logic       cpuHalt,
  output logic       mainOscStop,
  output logic       subOscStop,
  output logic       displayOff
);

  regSel_e   sel;
  pwrState_e stateQ, stateD;
  logic      wakeCond;

  assign sel = regSel_e'(wrSel);

  always_comb begin
    strobe         = '0;
    strobe.flagWr  = wrEn && (sel == SEL_FLAGS);
    strobe.ctrlWr  = wrEn && (sel == SEL_CTRL);
    strobe.watchWr = wrEn && (sel == SEL_WATCH);
    strobe.dirWr   = wrEn && (sel == SEL_DIR);
    strobe.ienWr   = wrEn && (sel == SEL_IEN);
  end

  // wake sources allowed per state
  always_comb begin
    unique case (stateQ)
      PWR_STANDBY: wakeCond = wakeSrc.nmiEvt | wakeSrc.irqPend;
      PWR_SLEEP1:  wakeCond = wakeSrc.portPend;
      PWR_SLEEP2:  wakeCond = wakeSrc.nmiEvt | wakeSrc.watchPend |
                              wakeSrc.portPend;
      default:     wakeCond = 1'b0;
    endcase
  end

  always_comb begin
    stateD = stateQ;
    if (stateQ == PWR_RUN) begin
      if (wrEn && sel == SEL_STANDBY) begin
        stateD = PWR_STANDBY;
      end else if (wrEn && sel == SEL_SLEEP) begin
        if (sleepBits[SLEEP1_BIT])      stateD = PWR_SLEEP1;
        else if (sleepBits[SLEEP2_BIT]) stateD = PWR_SLEEP2;
      end
    end else if (wakeCond) begin
      stateD = PWR_RUN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= PWR_RUN;
    else       stateQ <= stateD;
  end

  assign wakeEvt     = wakeCond;
  assign pwrState    = stateQ;
  assign cpuHalt     = (stateQ != PWR_RUN);
  assign mainOscStop = (stateQ == PWR_SLEEP1) || (stateQ == PWR_SLEEP2);
  assign subOscStop  = (stateQ == PWR_SLEEP1);
  assign displayOff  = (stateQ == PWR_SLEEP1);

endmodule

// File: rtl/irq_wake_ctrl.sv
module irq_wake_ctrl
  import irq_wake_pkg::*;
#(
  parameter int PINS   = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick64,
  input  logic              halfSecTick,
  input  logic              timerDone,
  input  logic [PINS-1:0]   portIn,
  input  logic              wrEn,
  input  logic [2:0]        wrSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [2:0]        rdFlags,
  output logic              irqReq,
  output logic              nmiPulse,
  output logic              wakeEvt,
  output logic [1:0]        pwrState,
  output logic              cpuHalt,
  output logic              mainOscStop,
  output logic              subOscStop,
  output logic              displayOff
);

  regStrobe_t strobe;
  wakeSrc_t   wakeSrc;

  irq_wake_dp #(.PINS(PINS), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .tick64(tick64), .halfSecTick(halfSecTick),
    .timerDone(timerDone), .portIn(portIn), .strobe(strobe),
    .wrData(wrData), .rdFlags(rdFlags), .irqReq(irqReq),
    .nmiPulse(nmiPulse), .wakeSrc(wakeSrc)
  );

  irq_wake_fsm u_fsm (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel),
    .sleepBits(wrData[1:0]), .wakeSrc(wakeSrc), .strobe(strobe),
    .pwrState(pwrState), .wakeEvt(wakeEvt), .cpuHalt(cpuHalt),
    .mainOscStop(mainOscStop), .subOscStop(subOscStop),
    .displayOff(displayOff)
  );

endmodule

// File: rtl/irq_wake_ctrl_chk.sv
module irq_wake_ctrl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              tick64,
  input logic              timerDone,
  input logic              wrEn,
  input logic [2:0]        wrSel,
  input logic [DATA_W-1:0] wrData,
  input logic [2:0]        rdFlags,
  input logic              irqReq,
  input logic              nmiPulse,
  input logic              wakeEvt,
  input logic [1:0]        pwrState,
  input logic              cpuHalt,
  input logic              mainOscStop,
  input logic              subOscStop,
  input logic              displayOff
);

  assert_clear_on_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 3'd0 && !wrData[1] && !timerDone) |=> !rdFlags[1]);

  assert_hold_unless_cleared_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rdFlags[1] && !(wrEn && wrSel == 3'd0 && !wrData[1])) |=> rdFlags[1]);

  assert_irq_needs_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (rdFlags != 3'd0));

  assert_nmi_after_tick_R5: assert property (@(posedge clk) disable iff (!rstN)
    nmiPulse |-> $past(tick64));

  assert_standby_keeps_osc_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'd1) |-> (cpuHalt && !mainOscStop && !subOscStop && !displayOff));

  assert_sleep1_port_only_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'd2 && !rdFlags[2]) |-> !wakeEvt);

  assert_sleep1_all_stop_R8: assert property (@(posedge clk) disable iff (!rstN)
    subOscStop |-> (mainOscStop && displayOff && cpuHalt));

  assert_sleep2_no_timer_wake_R9: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'd3 && !tick64 && !rdFlags[0] && !rdFlags[2]) |-> !wakeEvt);

  assert_no_wake_in_run_R11: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'd0) |-> !wakeEvt);

  assert_wake_to_run_R11: assert property (@(posedge clk) disable iff (!rstN)
    wakeEvt |=> (pwrState == 2'd0 && !cpuHalt && !mainOscStop && !subOscStop));

endmodule

bind irq_wake_ctrl irq_wake_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .tick64(tick64), .timerDone(timerDone),
  .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .rdFlags(rdFlags),
  .irqReq(irqReq), .nmiPulse(nmiPulse), .wakeEvt(wakeEvt),
  .pwrState(pwrState), .cpuHalt(cpuHalt), .mainOscStop(mainOscStop),
  .subOscStop(subOscStop), .displayOff(displayOff)
);

// File: tb/irq_wake_ctrl_tb.sv
module irq_wake_ctrl_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick64 = 1'b0, halfSecTick = 1'b0, timerDone = 1'b0;
  logic [7:0] portIn = 8'hFF;
  logic       wrEn = 1'b0;
  logic [2:0] wrSel = 3'd0;
  logic [7:0] wrData = 8'd0;
  logic [2:0] rdFlags;
  logic       irqReq, nmiPulse, wakeEvt, cpuHalt, mainOscStop, subOscStop, displayOff;
  logic [1:0] pwrState;

  int total = 0;
  int fails = 0;
  int benchPhase = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_wake_ctrl u_dut (
    .clk(clk), .rstN(rstN), .tick64(tick64), .halfSecTick(halfSecTick),
    .timerDone(timerDone), .portIn(portIn), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .rdFlags(rdFlags), .irqReq(irqReq), .nmiPulse(nmiPulse),
    .wakeEvt(wakeEvt), .pwrState(pwrState), .cpuHalt(cpuHalt),
    .mainOscStop(mainOscStop), .subOscStop(subOscStop), .displayOff(displayOff)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wrReg(input int sel, input int data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = 3'(sel); wrData = 8'(data);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulseTimer();
    @(negedge clk); timerDone = 1'b1;
    @(negedge clk); timerDone = 1'b0;
  endtask

  task automatic pulseTick64();
    @(negedge clk); tick64 = 1'b1;
    @(negedge clk); tick64 = 1'b0;
  endtask

  task automatic pulseHalf();
    @(negedge clk); halfSecTick = 1'b1;
    @(negedge clk); halfSecTick = 1'b0;
    benchPhase = 1 - benchPhase;
  endtask

  task automatic pulsePin0();
    @(negedge clk); portIn[0] = 1'b0;
    @(negedge clk); portIn[0] = 1'b1;
  endtask

  // pin 0 must be input + enabled, watch rate 2 Hz
  task automatic setFlags(input int p);
    wrReg(0, 0);
    if (p[0]) pulseHalf();
    if (p[1]) pulseTimer();
    if (p[2]) pulsePin0();
  endtask

  task automatic tickWake(input string req);
    @(negedge clk); tick64 = 1'b1;
    #1 chk({req, " wake strobe on tick"}, int'(wakeEvt), 1);
    @(negedge clk); tick64 = 1'b0;
    chk({req, " back to run"}, int'(pwrState), 0);
    chk({req, " nmi pulse with wake"}, int'(nmiPulse), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step();
    // R1 / R12 reset state
    chk("R1 flags reset", int'(rdFlags), 0);
    chk("R4 irq reset", int'(irqReq), 0);
    chk("R5 nmi reset", int'(nmiPulse), 0);
    chk("R12 state reset", int'(pwrState), 0);
    chk("R1 halt reset", int'(cpuHalt | mainOscStop | subOscStop | displayOff), 0);
    // R3 enables reset to 0: a low pin does nothing
    portIn = 8'h00; step(); step();
    chk("R3 reset enables ignore pins", int'(rdFlags[2]), 0);
    portIn = 8'hFF;

    // R5 NMI gating
    pulseTick64();
    chk("R5 nmi disabled", int'(nmiPulse), 0);
    wrReg(1, 8'h04);
    pulseTick64();
    chk("R5 nmi pulse", int'(nmiPulse), 1);
    step();
    chk("R5 nmi single cycle", int'(nmiPulse), 0);
    wrReg(1, 0);

    // R3 sweep over every pin, direction and enable
    for (int pin = 0; pin < 8; pin++) begin
      for (int d = 0; d < 2; d++) begin
        for (int e = 0; e < 2; e++) begin
          wrReg(3, d << pin);
          wrReg(4, e << pin);
          wrReg(0, 0);
          @(negedge clk); portIn = ~(8'd1 << pin);
          @(negedge clk);
          chk($sformatf("R3 pin%0d dir%0d en%0d", pin, d, e),
              int'(rdFlags[2]), (e == 1 && d == 0) ? 1 : 0);
          portIn = 8'hFF;
          step();
        end
      end
    end
    // R3 enabled pins held high do not interrupt
    wrReg(3, 0); wrReg(4, 8'hFF); wrReg(0, 0); step();
    chk("R3 high pins ignored", int'(rdFlags[2]), 0);
    // R3 level: clearing while held low re-sets
    @(negedge clk); portIn[3] = 1'b0;
    wrReg(0, 0);
    chk("R3 held-low re-set after clear", int'(rdFlags[2]), 1);
    chk("R4 irq stays while flag held", int'(irqReq), 1);
    portIn = 8'hFF;
    wrReg(4, 8'h01);

    // R1 / R4 sweep: enables x flag patterns
    for (int e = 0; e < 4; e++) begin
      for (int p = 0; p < 8; p++) begin
        wrReg(1, ((e & 1) << 1) | (((e >> 1) & 1) << 6));
        setFlags(p);
        chk($sformatf("R1 flag pattern %0d", p), int'(rdFlags), p);
        chk($sformatf("R4 irq e%0d p%0d", e, p), int'(irqReq),
            (((p & 1) != 0 && (e & 2) != 0) || ((p & 2) != 0 && (e & 1) != 0) ||
             (p & 4) != 0) ? 1 : 0);
      end
    end
    wrReg(1, 0);

    // R2 sweep: pattern x clear mask
    for (int p = 0; p < 8; p++) begin
      for (int m = 0; m < 8; m++) begin
        setFlags(p);
        wrReg(0, m);
        chk($sformatf("R2 p%0d mask%0d", p, m), int'(rdFlags), p & m);
      end
    end
    // R2 event wins over same-cycle clear
    wrReg(0, 0);
    @(negedge clk); wrEn = 1'b1; wrSel = 3'd0; wrData = 8'd0; timerDone = 1'b1;
    @(negedge clk); wrEn = 1'b0; timerDone = 1'b0;
    chk("R2 set beats clear", int'(rdFlags[1]), 1);

    // R6 watch rate
    for (int r = 0; r < 2; r++) begin
      wrReg(2, r);
      for (int k = 0; k < 4; k++) begin
        int expv;
        wrReg(0, 0);
        expv = (r == 0 || benchPhase == 1) ? 1 : 0;
        pulseHalf();
        chk($sformatf("R6 rate%0d tick%0d", r, k), int'(rdFlags[0]), expv);
      end
    end
    wrReg(2, 0);

    // R7 standby, NMI enabled, timer disabled
    wrReg(1, 8'h04); wrReg(0, 0);
    wrReg(5, 0);
    chk("R7 standby state", int'(pwrState), 1);
    chk("R7 standby halt", int'(cpuHalt), 1);
    chk("R7 standby osc/display", int'(mainOscStop | subOscStop | displayOff), 0);
    pulseTimer();
    chk("R7 disabled timer no wake", int'(wakeEvt), 0);
    step();
    chk("R7 still standby", int'(pwrState), 1);
    chk("R11 flags kept", int'(rdFlags), 2);
    tickWake("R7");
    // R7 standby woken by enabled timer
    wrReg(1, 8'h02); wrReg(0, 0);
    wrReg(5, 0);
    pulseTimer();
    chk("R7 timer wake strobe", int'(wakeEvt), 1);
    chk("R11 state before edge", int'(pwrState), 1);
    step();
    chk("R11 run after wake", int'(pwrState), 0);
    chk("R11 halt cleared", int'(cpuHalt), 0);

    // R8 sleep1
    wrReg(1, 8'h46); wrReg(0, 0);
    wrReg(6, 1);
    chk("R8 sleep1 state", int'(pwrState), 2);
    chk("R8 sleep1 stops", int'({cpuHalt, mainOscStop, subOscStop, displayOff}), 15);
    pulseTick64(); pulseTimer(); pulseHalf(); step();
    chk("R8 sleep1 ignores other sources", int'(pwrState), 2);
    @(negedge clk); portIn[0] = 1'b0;
    @(negedge clk);
    chk("R8 port wake strobe", int'(wakeEvt), 1);
    portIn[0] = 1'b1;
    @(negedge clk);
    chk("R8 run after port wake", int'(pwrState), 0);
    chk("R11 stops cleared", int'(mainOscStop | subOscStop | displayOff), 0);
    chk("R11 flags kept after wake", int'(rdFlags), 7);

    // R9 sleep2: timer ignored, NMI wakes
    wrReg(1, 8'h06); wrReg(0, 0);
    wrReg(6, 2);
    chk("R9 sleep2 state", int'(pwrState), 3);
    chk("R9 sleep2 stops", int'({cpuHalt, mainOscStop, subOscStop, displayOff}), 12);
    pulseTimer(); step();
    chk("R9 timer does not wake", int'(pwrState), 3);
    tickWake("R9");
    // R9 watch disabled: no wake, then port wakes
    wrReg(1, 0); wrReg(0, 0);
    wrReg(6, 2);
    pulseHalf(); step();
    chk("R9 disabled watch no wake", int'(pwrState), 3);
    pulsePin0(); step();
    chk("R9 port wakes sleep2", int'(pwrState), 0);
    // R9 watch enabled wakes
    wrReg(1, 8'h40); wrReg(0, 0);
    wrReg(6, 2);
    pulseHalf();
    chk("R9 watch wake strobe", int'(wakeEvt), 1);
    step();
    chk("R9 watch wakes sleep2", int'(pwrState), 0);

    // R10 priority and empty sleep write
    wrReg(1, 0); wrReg(0, 0);
    wrReg(6, 3);
    chk("R10 both bits give sleep1", int'(pwrState), 2);
    pulsePin0(); step();
    chk("R10 back to run", int'(pwrState), 0);
    wrReg(6, 0);
    chk("R10 no bits stays run", int'(pwrState), 0);
    chk("R10 no halt", int'(cpuHalt), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule